// File: doc/BRIEF.md
# Windowed Watchdog Timer with Quarter Mask

This block is a supervision timer that counts down from a programmable reload value. Its time base is the peripheral clock divided by a selectable prescaler. Software proves it is alive by writing a two-word key sequence. That refresh is accepted only while the elapsed time since the last reload falls in a quarter of the period that a 4-bit mask allows. The allowed quarters need not be adjacent, so the window can have gaps.

Two faults raise their own sticky flag: running out of count, and a refresh attempt that lands outside every allowed quarter. Both faults share one response, chosen at configuration time. The response is either a level interrupt, held while a flag is set, or a single-cycle reset request for the system reset controller.

The configuration word is accepted once after reset, and later writes are ignored. The counter can optionally freeze while a sleep indication is high.

Top module: `qwd_watchdog`

## Requirements
- R1: The period field selects a reload value of P-1, where P is 256, 4096, 16384 or 65536 for codes 0, 1, 2 and 3. The count port shows P-1 in the cycle after a reload.
- R2: The clock-select field sets the number of clocks per count step: code 2 gives 4, 6 gives 64, 7 gives 128, 8 gives 256, 9 gives 512, 0xA gives 1024, 0xB gives 2048 and 0xD gives 8192. After a reload the count first drops when that many clock edges have passed.
- R3: After reset the count reads 0, both flags are clear and both outputs are low. The counter stays idle, raising no flag, until the first valid refresh starts it. That first refresh is accepted whatever the mask holds.
- R4: Let elapsed = P-1-count, and let quarter = elapsed*4/P. Mask bit k allows refresh in quarter k, so bit 0 covers the first quarter after a reload and bit 3 covers the last. While running, a refresh in an allowed quarter reloads the counter. A refresh in any other quarter sets the refresh-error flag and leaves the count untouched.
- R5: A refresh is a key write of 0x0123 followed by a key write of 0x3210, and the counter reloads on the second key. Any other key value written between them discards the sequence. A second-key write that is not preceded by the first key does nothing.
- R6: When a count step occurs at count 0, the underflow flag is set. In the same cycle the counter reloads P-1 and keeps running.
- R7: With the response bit at 0, the interrupt output is high whenever either flag is set, and the reset request stays low. With the response bit at 1, every underflow or refresh error produces a one-cycle reset request, in the same cycle that the flag rises, and the interrupt stays low.
- R8: With the sleep-hold bit set, the count and the prescaler hold while the sleep input is high. With the bit clear, sleep has no effect.
- R9: The first configuration write after reset takes effect, and every later write is ignored until the next reset. Before that first write the defaults are period code 0, clock code 2, mask 0xF, sleep-hold 0 and response 0.
- R10: Each flag has its own clear input, and clearing one flag leaves the other untouched. If a new event and a clear occur in the same cycle, the flag stays set.
- R11: Clock-select codes that are not listed in R2 are reserved, and they divide by 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgPeriod | input | 2 | Period code |
| cfgClkSel | input | 4 | Prescaler code |
| cfgWindow | input | 4 | Allowed-quarter mask |
| cfgSleepHold | input | 1 | Freeze the counter during sleep |
| cfgRespReset | input | 1 | Response: 0 selects the interrupt, 1 selects the reset request |
| keyWe | input | 1 | Key write strobe |
| keyData | input | 16 | Key value |
| sleep | input | 1 | Sleep indication |
| clrUnderflow | input | 1 | Clears the underflow flag |
| clrRefreshErr | input | 1 | Clears the refresh-error flag |
| count | output | 16 | Current counter value |
| underflowFlag | output | 1 | Sticky underflow flag |
| refreshErrFlag | output | 1 | Sticky refresh-error flag |
| irqOut | output | 1 | Level interrupt |
| rstReqOut | output | 1 | One-cycle reset request |

## Verification
The quarter boundary is the first target. A design that decodes the wrong pair of count bits, or that measures position as remaining time rather than elapsed time, accepts refreshes in forbidden quarters under the gapped masks 0x5 and 0xA. The key sequence gets broken, repeated and unarmed second keys; a loose sequencer would reload on a stray 0x3210. Reserved prescaler codes, late configuration writes, sleep with hold on and off, and a clear arriving in the same cycle as a new event are all driven. A faulty design would show these as a wrong step rate, a period that changes after lock, a counter that drifts while asleep, or a lost flag. A reference model runs alongside every random cycle, so an off-by-one in the prescaler or in the underflow reload appears as a count mismatch.

// File: rtl/qwd_pkg.sv
package qwd_pkg;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_ARM  = 16'h0123;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'h3210;
  localparam int SHIFT_W = 4;

  // Control-to-datapath strobes
  typedef struct packed {
    logic reload;
    logic freeze;
  } qwdStrobe_t;

  // Prescaler code to log2 of the divide ratio; reserved codes take the slowest rate
  function automatic logic [SHIFT_W-1:0] clkSelToShift(input logic [3:0] code);
    case (code)
      4'h2, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB: return code;
      default: return 4'd13;
    endcase
  endfunction

  // Period code to number of counter bits in use
  function automatic int periodBits(input logic [1:0] sel);
    case (sel)
      2'd0: return 8;
      2'd1: return 12;
      2'd2: return 14;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/qwd_datapath.sv
module qwd_datapath
  import qwd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  qwdStrobe_t         strobe,
  input  logic [1:0]         periodSel,
  input  logic [SHIFT_W-1:0] divShift,
  output logic [CNT_W-1:0]   count,
  output logic [1:0]         quarter,
  output logic               running,
  output logic               underflow
);

  logic [CNT_W-1:0] reloadVal;
  logic [PRE_W-1:0] preLimit;
  logic [PRE_W-1:0] preCnt;
  logic             tick;

  always_comb begin
    reloadVal = CNT_W'((33'd1 << periodBits(periodSel)) - 33'd1);
    preLimit  = PRE_W'((32'd1 << divShift) - 32'd1);
  end

  // Elapsed quarter: inverted top two bits of the active counter width
  always_comb begin
    case (periodSel)
      2'd0:    quarter = ~count[7:6];
      2'd1:    quarter = ~count[11:10];
      2'd2:    quarter = ~count[13:12];
      default: quarter = ~count[15:14];
    endcase
  end

  assign tick      = running && !strobe.freeze && (preCnt == preLimit);
  assign underflow = tick && (count == '0) && !strobe.reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      count   <= '0;
      running <= 1'b0;
    end else if (strobe.reload) begin
      preCnt  <= '0;
      count   <= reloadVal;
      running <= 1'b1;
    end else if (running && !strobe.freeze) begin
      if (tick) begin
        preCnt <= '0;
        count  <= (count == '0) ? reloadVal : count - CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  AST_RELOAD_TO_TOP: assert property (@(posedge clk) disable iff (!rstN) strobe.reload |=> (count == $past(reloadVal)) && running) else $error("reload value"); // R1
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN) !running |-> count == '0) else $error("idle count"); // R3
  AST_UNDERFLOW_WRAPS: assert property (@(posedge clk) disable iff (!rstN) underflow |=> count == $past(reloadVal)) else $error("wrap value"); // R6
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN) strobe.freeze && !strobe.reload |=> $stable(count)) else $error("freeze"); // R8

endmodule

// File: rtl/qwd_ctrl.sv
module qwd_ctrl
  import qwd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgPeriod,
  input  logic [3:0]         cfgClkSel,
  input  logic [3:0]         cfgWindow,
  input  logic               cfgSleepHold,
  input  logic               cfgRespReset,
  input  logic               keyWe,
  input  logic [KEY_W-1:0]   keyData,
  input  logic               sleep,
  input  logic               clrUnderflow,
  input  logic               clrRefreshErr,
  input  logic [1:0]         quarter,
  input  logic               running,
  input  logic               underflow,
  output qwdStrobe_t         strobe,
  output logic [1:0]         periodSel,
  output logic [SHIFT_W-1:0] divShift,
  output logic               underflowFlag,
  output logic               refreshErrFlag,
  output logic               irqOut,
  output logic               rstReqOut
);

  logic       cfgLocked;
  logic [3:0] windowReg;
  logic       sleepHoldReg;
  logic       respResetReg;
  logic       armed;
  logic       fire;
  logic       inWindow;
  logic       refErr;

  // Write-once configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLocked    <= 1'b0;
      periodSel    <= 2'd0;
      divShift     <= clkSelToShift(4'h2);
      windowReg    <= 4'hF;
      sleepHoldReg <= 1'b0;
      respResetReg <= 1'b0;
    end else if (cfgWe && !cfgLocked) begin
      cfgLocked    <= 1'b1;
      periodSel    <= cfgPeriod;
      divShift     <= clkSelToShift(cfgClkSel);
      windowReg    <= cfgWindow;
      sleepHoldReg <= cfgSleepHold;
      respResetReg <= cfgRespReset;
    end
  end

  // Key sequencer: the first key arms, any other write disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (keyWe) armed <= (keyData == KEY_ARM);
  end

  assign fire          = keyWe && armed && (keyData == KEY_FIRE);
  assign inWindow      = windowReg[quarter];
  assign refErr        = fire && running && !inWindow;
  assign strobe.reload = fire && (!running || inWindow);
  assign strobe.freeze = sleepHoldReg && sleep;

  // Sticky flags (set wins over clear) and reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underflowFlag  <= 1'b0;
      refreshErrFlag <= 1'b0;
      rstReqOut      <= 1'b0;
    end else begin
      underflowFlag  <= underflow || (underflowFlag && !clrUnderflow);
      refreshErrFlag <= refErr || (refreshErrFlag && !clrRefreshErr);
      rstReqOut      <= respResetReg && (underflow || refErr);
    end
  end

  assign irqOut = !respResetReg && (underflowFlag || refreshErrFlag);

  AST_CFG_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rstN) cfgLocked |=> $stable(periodSel) && $stable(divShift) && $stable(windowReg) && $stable(sleepHoldReg) && $stable(respResetReg)) else $error("config changed"); // R9
  AST_KEY_DISARM: assert property (@(posedge clk) disable iff (!rstN) keyWe && (keyData != KEY_ARM) |=> !armed) else $error("sequence kept"); // R5
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rstN) underflowFlag && !clrUnderflow |=> underflowFlag) else $error("flag lost"); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN) clrRefreshErr && !refErr |=> !refreshErrFlag) else $error("clear failed"); // R10
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rstN) $rose(underflowFlag) && respResetReg |-> rstReqOut) else $error("no reset pulse"); // R7

endmodule

// File: rtl/qwd_watchdog.sv
module qwd_watchdog
  import qwd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgPeriod,
  input  logic [3:0]       cfgClkSel,
  input  logic [3:0]       cfgWindow,
  input  logic             cfgSleepHold,
  input  logic             cfgRespReset,
  input  logic             keyWe,
  input  logic [15:0]      keyData,
  input  logic             sleep,
  input  logic             clrUnderflow,
  input  logic             clrRefreshErr,
  output logic [CNT_W-1:0] count,
  output logic             underflowFlag,
  output logic             refreshErrFlag,
  output logic             irqOut,
  output logic             rstReqOut
);

  qwdStrobe_t         strobe;
  logic [1:0]         periodSel;
  logic [SHIFT_W-1:0] divShift;
  logic [1:0]         quarter;
  logic               running;
  logic               underflow;

  qwd_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cfgWe          (cfgWe),
    .cfgPeriod      (cfgPeriod),
    .cfgClkSel      (cfgClkSel),
    .cfgWindow      (cfgWindow),
    .cfgSleepHold   (cfgSleepHold),
    .cfgRespReset   (cfgRespReset),
    .keyWe          (keyWe),
    .keyData        (keyData),
    .sleep          (sleep),
    .clrUnderflow   (clrUnderflow),
    .clrRefreshErr  (clrRefreshErr),
    .quarter        (quarter),
    .running        (running),
    .underflow      (underflow),
    .strobe         (strobe),
    .periodSel      (periodSel),
    .divShift       (divShift),
    .underflowFlag  (underflowFlag),
    .refreshErrFlag (refreshErrFlag),
    .irqOut         (irqOut),
    .rstReqOut      (rstReqOut)
  );

  qwd_datapath #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .periodSel (periodSel),
    .divShift  (divShift),
    .count     (count),
    .quarter   (quarter),
    .running   (running),
    .underflow (underflow)
  );

endmodule

// File: tb/tb_qwd_watchdog.sv
module tb_qwd_watchdog;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] K1 = 16'h0123;
  localparam logic [15:0] K2 = 16'h3210;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgSleepHold = 1'b0, cfgRespReset = 1'b0;
  logic [1:0]  cfgPeriod = '0;
  logic [3:0]  cfgClkSel = '0, cfgWindow = '0;
  logic        keyWe = 1'b0, sleep = 1'b0, clrUnderflow = 1'b0, clrRefreshErr = 1'b0;
  logic [15:0] keyData = '0;
  logic [15:0] count;
  logic        underflowFlag, refreshErrFlag, irqOut, rstReqOut;

  int errors = 0;
  int checks = 0;

  qwd_watchdog dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPeriod(cfgPeriod), .cfgClkSel(cfgClkSel),
    .cfgWindow(cfgWindow), .cfgSleepHold(cfgSleepHold), .cfgRespReset(cfgRespReset),
    .keyWe(keyWe), .keyData(keyData), .sleep(sleep), .clrUnderflow(clrUnderflow),
    .clrRefreshErr(clrRefreshErr), .count(count), .underflowFlag(underflowFlag),
    .refreshErrFlag(refreshErrFlag), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  function automatic int topOf(input logic [1:0] p);
    case (p)
      2'd0: return 255;
      2'd1: return 4095;
      2'd2: return 16383;
      default: return 65535;
    endcase
  endfunction

  function automatic int divOf(input logic [3:0] c);
    case (c)
      4'h2: return 4;
      4'h6: return 64;
      4'h7: return 128;
      4'h8: return 256;
      4'h9: return 512;
      4'hA: return 1024;
      4'hB: return 2048;
      default: return 8192;
    endcase
  endfunction

  function automatic int quarterOf(input int cnt, input logic [1:0] p);
    int per;
    per = topOf(p) + 1;
    return ((per - 1 - cnt) * 4) / per;
  endfunction

  // Reference model, built from the requirements
  logic mLocked, mSleepHold, mResp, mArmed, mRun, mUf, mRe, mRst;
  logic [1:0] mPeriod;
  logic [3:0] mClk, mWin;
  int mCnt, mPre;
  logic eFire, eInWin, eReload, eErr, eFrz, eTick, eUfe;

  always @(posedge clk) begin
    if (!rstN) begin
      mLocked <= 0; mPeriod <= 0; mClk <= 4'h2; mWin <= 4'hF; mSleepHold <= 0; mResp <= 0;
      mArmed <= 0; mRun <= 0; mCnt <= 0; mPre <= 0; mUf <= 0; mRe <= 0; mRst <= 0;
    end else begin
      eFire   = keyWe && mArmed && (keyData == K2);
      eInWin  = mWin[quarterOf(mCnt, mPeriod)];
      eReload = eFire && (!mRun || eInWin);
      eErr    = eFire && mRun && !eInWin;
      eFrz    = mSleepHold && sleep;
      eTick   = mRun && !eFrz && (mPre == divOf(mClk) - 1);
      eUfe    = eTick && (mCnt == 0) && !eReload;
      if (cfgWe && !mLocked) begin
        mLocked <= 1; mPeriod <= cfgPeriod; mClk <= cfgClkSel; mWin <= cfgWindow;
        mSleepHold <= cfgSleepHold; mResp <= cfgRespReset;
      end
      if (keyWe) mArmed <= (keyData == K1);
      if (eReload) begin
        mCnt <= topOf(mPeriod); mPre <= 0; mRun <= 1;
      end else if (mRun && !eFrz) begin
        if (eTick) begin
          mPre <= 0;
          mCnt <= (mCnt == 0) ? topOf(mPeriod) : mCnt - 1;
        end else begin
          mPre <= mPre + 1;
        end
      end
      mUf  <= eUfe || (mUf && !clrUnderflow);
      mRe  <= eErr || (mRe && !clrRefreshErr);
      mRst <= mResp && (eUfe || eErr);
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(int'(count) == mCnt, tag, "count", int'(count), mCnt);
    check(underflowFlag == mUf, tag, "underflowFlag", int'(underflowFlag), int'(mUf));
    check(refreshErrFlag == mRe, tag, "refreshErrFlag", int'(refreshErrFlag), int'(mRe));
    check(irqOut == (!mResp && (mUf || mRe)), tag, "irqOut", int'(irqOut), int'(!mResp && (mUf || mRe)));
    check(rstReqOut == mRst, tag, "rstReqOut", int'(rstReqOut), int'(mRst));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; cfgWe = 0; keyWe = 0; sleep = 0; clrUnderflow = 0; clrRefreshErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic writeCfg(input logic [1:0] p, input logic [3:0] c, input logic [3:0] w,
                          input logic s, input logic r);
    @(negedge clk);
    cfgWe = 1; cfgPeriod = p; cfgClkSel = c; cfgWindow = w; cfgSleepHold = s; cfgRespReset = r;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic keyWrite(input logic [15:0] v);
    @(negedge clk);
    keyWe = 1; keyData = v;
    @(negedge clk);
    keyWe = 0;
  endtask

  task automatic refresh();
    keyWrite(K1);
    keyWrite(K2);
  endtask

  task automatic idle(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      compareAll(tag);
    end
  endtask

  task automatic randomRun(input int n, input int keyRate, input string tag);
    bit pend = 0;
    int r;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll(tag);
      keyWe = 0; clrUnderflow = 0; clrRefreshErr = 0;
      r = $urandom_range(0, 999);
      if (pend) begin
        keyWe = 1; keyData = (r < 900) ? K2 : 16'($urandom); pend = 0;
      end else if (r < keyRate) begin
        keyWe = 1; keyData = K1; pend = 1;
      end else if (r < keyRate + 2) begin
        keyWe = 1; keyData = 16'($urandom);
      end
      if ($urandom_range(0, 99) < 2) clrUnderflow = 1;
      if ($urandom_range(0, 99) < 2) clrRefreshErr = 1;
      if ($urandom_range(0, 399) == 0) sleep = ~sleep;
    end
    @(negedge clk);
    keyWe = 0; clrUnderflow = 0; clrRefreshErr = 0; sleep = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'd5150));
    // Phase A: period 256, divide by 4, gapped mask 0x5, sleep hold on
    doReset();
    @(negedge clk);
    check(count == 0 && !underflowFlag && !refreshErrFlag && !irqOut && !rstReqOut, "R3", "reset state", int'(count), 0);
    idle(300, "R3 idle");
    check(count == 0 && !underflowFlag, "R3", "idle before start", int'(count), 0);
    writeCfg(2'd0, 4'h2, 4'h5, 1'b1, 1'b0);
    refresh();
    check(count == 255, "R1", "count after first refresh", int'(count), 255);
    idle(3, "R2");
    check(count == 255, "R2", "no step before 4 clocks", int'(count), 255);
    idle(1, "R2");
    check(count == 254, "R2", "step at 4 clocks", int'(count), 254);
    idle(1019, "R6");
    check(!underflowFlag && count == 0, "R6", "just before underflow", int'(count), 0);
    idle(1, "R6");
    check(underflowFlag && count == 255, "R6", "wrap and flag", int'(count), 255);
    check(irqOut && !rstReqOut, "R7", "interrupt level", int'(irqOut), 1);
    @(negedge clk); clrUnderflow = 1;
    @(negedge clk); clrUnderflow = 0;
    check(!underflowFlag && !irqOut, "R10", "underflow cleared", int'(underflowFlag), 0);
    idle(300, "R4");
    c0 = int'(count);
    refresh();
    check(refreshErrFlag == 1, "R4", "refresh in disallowed quarter", int'(refreshErrFlag), 1);
    check(int'(count) < c0 && int'(count) == mCnt, "R4", "no reload on error", int'(count), mCnt);
    @(negedge clk); sleep = 1; c0 = int'(count);
    idle(100, "R8");
    check(int'(count) == c0, "R8", "frozen in sleep", int'(count), c0);
    @(negedge clk); sleep = 0;
    randomRun(6000, 2, "R4 R6 R8 R10");

    // Phase B: reset response, mask 0xA, no sleep hold
    doReset();
    writeCfg(2'd0, 4'h2, 4'hA, 1'b0, 1'b1);
    refresh();
    idle(1023, "R7");
    idle(1, "R7");
    check(rstReqOut && underflowFlag && !irqOut, "R7", "reset pulse on underflow", int'(rstReqOut), 1);
    idle(1, "R7");
    check(!rstReqOut, "R7", "reset pulse one cycle", int'(rstReqOut), 0);
    @(negedge clk); sleep = 1; c0 = int'(count);
    idle(8, "R8");
    check(int'(count) != c0, "R8", "sleep ignored without hold", int'(count), c0 - 2);
    @(negedge clk); sleep = 0;
    randomRun(12000, 1, "R5 R7 R10");

    // Phase D: write-once configuration and key sequencing
    doReset();
    writeCfg(2'd1, 4'h2, 4'hF, 1'b0, 1'b0);
    writeCfg(2'd0, 4'h6, 4'h0, 1'b1, 1'b1);
    refresh();
    check(count == 4095, "R9", "second config ignored (period)", int'(count), 4095);
    check(count == 4095, "R1", "period code 1 reload", int'(count), 4095);
    idle(4, "R9");
    check(count == 4094, "R9", "second config ignored (divider)", int'(count), 4094);
    idle(100, "R5");
    keyWrite(K1); keyWrite(16'hBEEF); keyWrite(K2);
    check(int'(count) != 4095 && int'(count) == mCnt, "R5", "broken sequence discarded", int'(count), mCnt);
    keyWrite(K2);
    check(int'(count) != 4095 && !refreshErrFlag, "R5", "unarmed second key ignored", int'(count), mCnt);
    keyWrite(K1); keyWrite(K1); keyWrite(K2);
    check(count == 4095, "R5", "re-armed sequence reloads", int'(count), 4095);

    // Phase C: reserved prescaler code
    doReset();
    writeCfg(2'd0, 4'h3, 4'hF, 1'b0, 1'b0);
    refresh();
    idle(8191, "R11");
    check(count == 255, "R11", "no step before 8192 clocks", int'(count), 255);
    idle(1, "R11");
    check(count == 254, "R11", "step at 8192 clocks", int'(count), 254);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule